// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block hands out memory addresses for a data buffer that is walked as a ring. Four parameters define the walk: the first address of the window, the number of words in it, a signed step and the current position. A register-write port loads them. Every time the consumer pulses the strobe, the block presents the current position as a registered address one cycle later. It then moves the position by the step. If the move crosses either end of the window, the position folds back inside the window by the window size. The consumer therefore gets an unending address sequence without any software bookkeeping.

A second output mapping supports transform-style reordering. The distance from the window start is formed, and its low bits are mirrored before the window start is added back. A window size of zero turns the folding off, and the position then simply accumulates the step modulo the address space.

Top module: `circ_addr_gen`

## Requirements
- R1: After synchronous reset, `addr_out` is 0 and `addr_valid` is 0. The start, the size and the position are all 0, and the step is +1, so the first two strobes yield addresses 0 and 1.
- R2: A strobe (`step_req` high at a clock edge) makes `addr_valid` high after that edge, with `addr_out` equal to the position as it stood before the update. Without a strobe, `addr_valid` is low after the edge and `addr_out` keeps its last value.
- R3: With a nonzero size L and start B, if position plus step is at or above B+L, the new position is position + step − L.
- R4: The step is an AW-bit two's-complement value. With a nonzero size, if position plus a negative step falls below B, the new position is position + step + L.
- R5: With size 0, the new position is (position + step) modulo 2^AW, with no folding.
- R6: `wr_sel` encodes the target as 0 = start, 1 = size, 2 = step, 3 = position. A write to the start also loads the position with the written value.
- R7: A write to the position (select 3) sets the address returned by the next strobe.
- R8: In a cycle with neither a strobe nor a write, the position does not change.
- R9: With `brev_en` high on a strobe, the output is start + offset', where offset = position − start (mod 2^AW). In offset', the low BR_BITS bits of offset are reversed in order and the upper bits are unchanged.
- R10: When a write and a strobe share a cycle, the strobe outputs the old position. A start or position write replaces the stepped value. A size or step write takes effect only from the next cycle, so the position advances with the old parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Parameter write enable |
| wr_sel | input | 2 | Parameter select (0 start, 1 size, 2 step, 3 position) |
| wr_data | input | AW | Parameter write value |
| step_req | input | 1 | Strobe requesting the next address |
| brev_en | input | 1 | Bit-reversed offset mapping for this strobe |
| addr_out | output | AW | Registered address |
| addr_valid | output | 1 | High for one cycle after each strobe |

## Verification
The bench targets the fold at both ends of the window.

- **Strides that do not divide the size.** Step 3 on a size of 10 catches an off-by-one at B+L; such a design would emit B+L itself or skip B.
- **Negative steps.** These catch a design that treats the step as unsigned, because it leaves the window upward.
- **Step equal to the size.** The position must return to itself every strobe.
- **Size zero.** This is run across the top of the address space, where a design that folds anyway, or clamps, diverges.
- **Bit-reversed mapping.** This is run at a start that is not aligned to the window and with an offset above 2^BR_BITS, which exposes a design that mirrors absolute address bits.
- **Same-cycle writes and strobes.** These expose a wrong priority between the stepped and the written position.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;
  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_LEN  = 2'd1,
    SEL_STEP = 2'd2,
    SEL_IDX  = 2'd3
  } cbuf_sel_e;
endpackage

// File: rtl/cbuf_wrap.sv
// Next-position computation: add the signed step, then fold into the window.
module cbuf_wrap #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] step,
  output logic [AW-1:0] nxt
);
  localparam int EW = AW + 2;

  logic signed [EW-1:0] sum;
  logic signed [EW-1:0] hi_lim;
  logic signed [EW-1:0] lo_lim;
  logic signed [EW-1:0] len_x;
  logic signed [EW-1:0] res;

  always_comb begin
    len_x  = $signed({2'b00, len});
    lo_lim = $signed({2'b00, base});
    hi_lim = lo_lim + len_x;
    sum    = $signed({2'b00, idx}) + $signed({{2{step[AW-1]}}, step});
    if (len == '0)
      res = sum;
    else if (sum >= hi_lim)
      res = sum - len_x;
    else if (sum < lo_lim)
      res = sum + len_x;
    else
      res = sum;
    nxt = res[AW-1:0];
  end
endmodule

// File: rtl/cbuf_brev.sv
// Mirror the low RB bits of the offset from the window start.
module cbuf_brev #(
  parameter int AW = 16,
  parameter int RB = 4
) (
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] off;
  logic [RB-1:0] rev;
  logic [AW-1:0] mapped;

  assign off = idx - base;

  for (genvar g = 0; g < RB; g++) begin : g_rev
    assign rev[g] = off[RB-1-g];
  end

  if (RB < AW) begin : g_keep_hi
    assign mapped = {off[AW-1:RB], rev};
  end else begin : g_all_rev
    assign mapped = rev[AW-1:0];
  end

  assign addr = base + mapped;
endmodule

// File: rtl/cbuf_regs.sv
// Parameter registers and the running position.
module cbuf_regs
  import cbuf_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          adv,
  input  logic [AW-1:0] nxt_idx,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] len_q,
  output logic [AW-1:0] step_q,
  output logic [AW-1:0] idx_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      len_q  <= '0;
      step_q <= AW'(1);
      idx_q  <= '0;
    end else begin
      if (adv) idx_q <= nxt_idx;
      if (wr_en) begin
        case (cbuf_sel_e'(wr_sel))
          SEL_BASE: begin
            base_q <= wr_data;
            idx_q  <= wr_data;
          end
          SEL_LEN:  len_q  <= wr_data;
          SEL_STEP: step_q <= wr_data;
          SEL_IDX:  idx_q  <= wr_data;
          default:  ;
        endcase
      end
    end
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!adv && !wr_en) |=> $stable(idx_q));

  // R6
  base_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0) |=> (idx_q == $past(wr_data) && base_q == $past(wr_data)));

  // R10
  step_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd2) |=> (step_q == $past(wr_data)));
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
  parameter int AW      = 16,
  parameter int BR_BITS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          step_req,
  input  logic          brev_en,
  output logic [AW-1:0] addr_out,
  output logic          addr_valid
);
  logic [AW-1:0] base_q, len_q, step_q, idx_q;
  logic [AW-1:0] nxt_idx, brev_addr;

  cbuf_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .adv(step_req), .nxt_idx(nxt_idx),
    .base_q(base_q), .len_q(len_q), .step_q(step_q), .idx_q(idx_q)
  );

  cbuf_wrap #(.AW(AW)) u_wrap (
    .idx(idx_q), .base(base_q), .len(len_q), .step(step_q), .nxt(nxt_idx)
  );

  cbuf_brev #(.AW(AW), .RB(BR_BITS)) u_brev (
    .idx(idx_q), .base(base_q), .addr(brev_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_out   <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= step_req;
      if (step_req) addr_out <= brev_en ? brev_addr : idx_q;
    end
  end

  // Window-membership helpers for checking.
  logic [AW:0]   win_end;
  logic          in_win;
  logic [AW-1:0] step_mag;
  assign win_end  = {1'b0, base_q} + {1'b0, len_q};
  assign in_win   = (len_q != '0) && (idx_q >= base_q) && ({1'b0, idx_q} < win_end);
  assign step_mag = step_q[AW-1] ? (~step_q + AW'(1)) : step_q;

  // R3
  stay_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    (step_req && !wr_en && in_win && step_mag <= len_q) |=> in_win);

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    step_req |=> addr_valid);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_req |=> (!addr_valid && $stable(addr_out)));
endmodule

// File: tb/circ_addr_gen_test.sv
module circ_addr_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int RB = 4;
  localparam int MOD = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en;
  logic [1:0]    wr_sel;
  logic [AW-1:0] wr_data;
  logic          step_req;
  logic          brev_en;
  logic [AW-1:0] addr_out;
  logic          addr_valid;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_base, m_len, m_step, m_idx, m_addr, m_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  circ_addr_gen #(.AW(AW), .BR_BITS(RB)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .step_req(step_req), .brev_en(brev_en), .addr_out(addr_out), .addr_valid(addr_valid)
  );

  function automatic int wrapm(input int v);
    return ((v % MOD) + MOD) % MOD;
  endfunction

  function automatic int model_next(input int idx);
    int s;
    s = idx + m_step;
    if (m_len != 0) begin
      if (s >= m_base + m_len) s = s - m_len;
      else if (s < m_base)     s = s + m_len;
    end
    return wrapm(s);
  endfunction

  function automatic int model_brev(input int idx);
    int off, low, rev;
    off = wrapm(idx - m_base);
    low = off % (1 << RB);
    rev = 0;
    for (int b = 0; b < RB; b++)
      if (((low >> b) & 1) != 0) rev = rev | (1 << (RB - 1 - b));
    return wrapm(m_base + (off - low) + rev);
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Drive one cycle, advance the model, compare at the next falling edge.
  task automatic cyc(input logic we, input int sel, input int d,
                     input logic req, input logic br, input string tag);
    int nidx;
    wr_en = we; wr_sel = sel[1:0]; wr_data = d[AW-1:0];
    step_req = req; brev_en = br;
    @(posedge clk);
    nidx = m_idx;
    if (req) begin
      m_addr  = br ? model_brev(m_idx) : m_idx;
      m_valid = 1;
      nidx    = model_next(m_idx);
    end else begin
      m_valid = 0;
    end
    if (we) begin
      case (sel)
        0: begin m_base = wrapm(d); nidx = wrapm(d); end
        1: m_len = wrapm(d);
        2: m_step = (wrapm(d) >= MOD/2) ? wrapm(d) - MOD : wrapm(d);
        default: nidx = wrapm(d);
      endcase
    end
    m_idx = nidx;
    @(negedge clk);
    check(tag, "addr_valid", int'(addr_valid), m_valid);
    check(tag, "addr_out", int'(addr_out), m_addr);
  endtask

  task automatic wr(input int sel, input int d, input string tag);
    cyc(1'b1, sel, d, 1'b0, 1'b0, tag);
  endtask

  task automatic strobes(input int n, input logic br, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 1'b1, br, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 0; wr_sel = 0; wr_data = 0; step_req = 0; brev_en = 0;
    m_base = 0; m_len = 0; m_step = 1; m_idx = 0; m_addr = 0; m_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset addr_valid", int'(addr_valid), 0);
    check("R1", "reset addr_out", int'(addr_out), 0);
    rst = 1'b0;

    // R1 / R2: default parameters, then idle cycles (R8)
    strobes(2, 1'b0, "R1");
    cyc(1'b0, 0, 0, 1'b0, 1'b0, "R2");
    cyc(1'b0, 0, 0, 1'b0, 1'b0, "R8");
    strobes(1, 1'b0, "R8");

    // R6 / R3: window of 8 starting at 100, unit step
    wr(1, 8, "R6");
    wr(0, 100, "R6");
    strobes(1, 1'b0, "R6");
    strobes(10, 1'b0, "R3");

    // R3: step 3 on size 10, strobes with gaps
    wr(1, 10, "R3");
    wr(2, 3, "R3");
    wr(0, 200, "R3");
    for (int i = 0; i < 8; i++) begin
      strobes(2, 1'b0, "R3");
      cyc(1'b0, 0, 0, 1'b0, 1'b0, "R8");
    end

    // R4: negative step, then step equal to the size
    wr(2, MOD - 3, "R4");
    strobes(12, 1'b0, "R4");
    wr(2, MOD - 10, "R4");
    strobes(3, 1'b0, "R4");
    wr(2, 10, "R3");
    strobes(3, 1'b0, "R3");

    // R5: size zero, crossing the top and the bottom of the address space
    wr(1, 0, "R5");
    wr(0, 0, "R5");
    wr(3, MOD - 6, "R5");
    wr(2, 4, "R5");
    strobes(4, 1'b0, "R5");
    wr(2, MOD - 5, "R5");
    strobes(4, 1'b0, "R5");

    // R7: explicit position write inside a window
    wr(0, 300, "R7");
    wr(1, 20, "R7");
    wr(2, 7, "R7");
    wr(3, 315, "R7");
    strobes(6, 1'b0, "R7");

    // R9: bit-reversed mapping, aligned and unaligned starts
    wr(0, 64, "R9");
    wr(1, 16, "R9");
    wr(2, 1, "R9");
    strobes(20, 1'b1, "R9");
    wr(0, 4097, "R9");
    wr(1, 40, "R9");
    wr(2, 3, "R9");
    strobes(20, 1'b1, "R9");

    // R10: writes coinciding with strobes
    wr(0, 500, "R10");
    wr(1, 12, "R10");
    wr(2, 5, "R10");
    cyc(1'b1, 2, 2, 1'b1, 1'b0, "R10");
    strobes(3, 1'b0, "R10");
    cyc(1'b1, 3, 507, 1'b1, 1'b0, "R10");
    strobes(2, 1'b0, "R10");
    cyc(1'b1, 0, 900, 1'b1, 1'b0, "R10");
    strobes(2, 1'b0, "R10");
    cyc(1'b1, 1, 4, 1'b1, 1'b0, "R10");
    strobes(4, 1'b0, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule